// File: doc/BRIEF.md
# Dual-Mode Multi-Function Barrel Shifter

A variable-amount shifter intended for aligning and renormalising floating-point mantissas. A single 64-bit data word is either shifted as a whole, or treated as two independent 32-bit halves that each carry their own operation and amount. Every shifter offers logical right, arithmetic right, left shift, rotate right and rotate left. During a logical right shift it also reports a sticky flag: the OR of every bit that dropped off the bottom. A rounding stage needs exactly this flag.

Lane A is the joined 64-bit shifter or, in split mode, the lower half. Lane B is the upper half and is used only in split mode. Optional register banks sit at the inputs and at the outputs, chosen by parameters. Both banks use one clock, one asynchronous active-low reset and one clock enable. With both banks present the result appears two clock edges after the inputs are captured.

Top module: `dual_mode_shifter`

## Requirements
- R1: With `split`=0, `dout` is the 64-bit shift of `din` under `op_a` and the 6-bit `amt_a`. `op_b` and `amt_b` have no effect on any output.
- R2: With `split`=1, `dout[31:0]` is `din[31:0]` shifted by `op_a` and `amt_a[4:0]`, and `dout[63:32]` is `din[63:32]` shifted by `op_b` and `amt_b`. `amt_a[5]` is ignored, and `sticky_a` and `sticky_b` belong to the lower and upper halves respectively.
- R3: Operation code 3'b000 is a logical right shift with zero fill. The lane's sticky output is the OR of the bits shifted out.
- R4: Operation code 3'b001 is an arithmetic right shift that fills with the lane's top bit.
- R5: Operation code 3'b010 is a left shift with zero fill into the low bits.
- R6: Operation codes 3'b011 and 3'b100 are rotate right and rotate left. Bits leaving one end of the lane re-enter at the other end.
- R7: An amount of zero, or an operation code from 3'b101 to 3'b111, passes the lane's data through unchanged. During a logical right shift by zero the sticky output is 0.
- R8: With both register banks present (the defaults), a result reaches the outputs at the second rising edge after its inputs are applied. While `rst_n` is low, `dout`, `sticky_a` and `sticky_b` are 0.
- R9: While `en` is low, the outputs hold their value regardless of input changes.
- R10: In joined mode `sticky_b` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register banks |
| rst_n | input | 1 | Asynchronous active-low reset of both banks |
| en | input | 1 | Clock enable shared by both banks |
| split | input | 1 | 1 = two 32-bit shifters, 0 = one 64-bit shifter |
| op_a | input | 3 | Operation of lane A |
| amt_a | input | 6 | Shift amount of lane A (bit 5 used only when joined) |
| op_b | input | 3 | Operation of lane B (split mode) |
| amt_b | input | 5 | Shift amount of lane B (split mode) |
| din | input | 64 | Data to shift |
| dout | output | 64 | Shifted data |
| sticky_a | output | 1 | Sticky flag of lane A |
| sticky_b | output | 1 | Sticky flag of lane B |

## Verification
Hand-computed vectors cover each operation at small amounts, at the half-width amount of 32, and at the extremes of 0 and 63. These cases separate fill and wrap behaviour, and they show whether the amount bits are weighted correctly. Split-mode vectors give the two halves different operations, and one of them sets `amt_a[5]`. Leakage of lane A's controls into lane B, or carry of bits across the half boundary, then produces a wrong word. Random operations, amounts and split settings are compared with a bit-by-bit reference model that also checks both sticky flags. Directed steps observe the two-edge latency, the hold under a low enable, and the cleared state under reset.

// File: rtl/dual_mode_shifter.sv
module dual_mode_shifter #(
  parameter int W       = 64,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   split,
  input  logic [2:0]             op_a,
  input  logic [$clog2(W)-1:0]   amt_a,
  input  logic [2:0]             op_b,
  input  logic [$clog2(W)-2:0]   amt_b,
  input  logic [W-1:0]           din,
  output logic [W-1:0]           dout,
  output logic                   sticky_a,
  output logic                   sticky_b
);
  localparam int H   = W / 2;
  localparam int AW  = $clog2(W);
  localparam int HAW = AW - 1;

  localparam logic [2:0] OP_LSR = 3'd0;
  localparam logic [2:0] OP_ASR = 3'd1;
  localparam logic [2:0] OP_LSL = 3'd2;
  localparam logic [2:0] OP_ROR = 3'd3;
  localparam logic [2:0] OP_ROL = 3'd4;

  logic           p_split;
  logic [2:0]     p_opa, p_opb;
  logic [AW-1:0]  p_amta;
  logic [HAW-1:0] p_amtb;
  logic [W-1:0]   p_din;

  logic [W-1:0]   r_out;
  logic           r_sa, r_sb;

  generate
    if (IN_REG) begin : g_in_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p_split <= 1'b0;
          p_opa   <= '0;
          p_opb   <= '0;
          p_amta  <= '0;
          p_amtb  <= '0;
          p_din   <= '0;
        end else if (en) begin
          p_split <= split;
          p_opa   <= op_a;
          p_opb   <= op_b;
          p_amta  <= amt_a;
          p_amtb  <= amt_b;
          p_din   <= din;
        end
      end
    end else begin : g_in_wire
      assign p_split = split;
      assign p_opa   = op_a;
      assign p_opb   = op_b;
      assign p_amta  = amt_a;
      assign p_amtb  = amt_b;
      assign p_din   = din;
    end
  endgenerate

  // lane 0: joined W bits, lane 1: lower half, lane 2: upper half
  generate
    for (genvar g = 0; g < 3; g++) begin : lane
      localparam int LW  = (g == 0) ? W : H;
      localparam int LAW = (g == 0) ? AW : HAW;

      logic [LW-1:0]  x, y;
      logic [2:0]     op;
      logic [LAW-1:0] n;
      logic           st;

      function automatic logic [LW:0] shf(input logic [LW-1:0] xi,
                                          input logic [2:0] o,
                                          input logic [LAW-1:0] a);
        logic [LW-1:0]  d, e, ones;
        logic [LAW-1:0] m;
        logic           fill, rot, s;
        ones = '1;
        s    = 1'b0;
        rot  = (o == OP_ROR) || (o == OP_ROL);
        fill = (o == OP_ASR) && xi[LW-1];
        m    = (o <= OP_ROL) ? a : '0;
        if (o == OP_ROL) m = '0 - a;
        d = xi;
        if (o == OP_LSL)
          for (int i = 0; i < LW; i++) d[i] = xi[LW-1-i];
        for (int k = 0; k < LAW; k++) begin
          if (m[k]) begin
            s = s | (|(d & ~(ones << (1 << k))));
            if (rot) d = (d >> (1 << k)) | (d << (LW - (1 << k)));
            else     d = (d >> (1 << k)) | (fill ? ~(ones >> (1 << k)) : '0);
          end
        end
        e = d;
        if (o == OP_LSL)
          for (int i = 0; i < LW; i++) e[i] = d[LW-1-i];
        return {s & (o == OP_LSR), e};
      endfunction

      if (g == 0) begin : g_src
        assign x  = p_din;
        assign op = p_opa;
        assign n  = p_amta;
      end else if (g == 1) begin : g_src
        assign x  = p_din[H-1:0];
        assign op = p_opa;
        assign n  = p_amta[HAW-1:0];
      end else begin : g_src
        assign x  = p_din[W-1:H];
        assign op = p_opb;
        assign n  = p_amtb;
      end

      assign {st, y} = shf(x, op, n);
    end
  endgenerate

  assign r_out = p_split ? {lane[2].y, lane[1].y} : lane[0].y;
  assign r_sa  = p_split ? lane[1].st : lane[0].st;
  assign r_sb  = p_split ? lane[2].st : 1'b0;

  generate
    if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dout     <= '0;
          sticky_a <= 1'b0;
          sticky_b <= 1'b0;
        end else if (en) begin
          dout     <= r_out;
          sticky_a <= r_sa;
          sticky_b <= r_sb;
        end
      end

      // R9
      hold_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout) && $stable(sticky_a) && $stable(sticky_b));
    end else begin : g_out_wire
      assign dout     = r_out;
      assign sticky_a = r_sa;
      assign sticky_b = r_sb;
    end
  endgenerate

  // R3
  lsr_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_split && p_opa == OP_LSR && p_amta != '0) |-> !r_out[W-1]);

  // R4
  asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_split && p_opa == OP_ASR) |-> (r_out[W-1] == p_din[W-1]));

  // R5
  lsl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_split && p_opa == OP_LSL && p_amta != '0) |-> !r_out[0]);

  // R6
  rot_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_split && (p_opa == OP_ROR || p_opa == OP_ROL)) |->
    ($countones(r_out) == $countones(p_din)));

  // R7
  zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_split && p_amta == '0) |-> (r_out == p_din && !r_sa));

  // R2
  split_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_split && p_opa == OP_LSL && p_amta[HAW-1:0] != '0) |-> !r_out[0]);

  // R2
  split_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_split && p_opb == OP_LSR && p_amtb != '0) |-> !r_out[W-1]);

  // R10
  joined_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !p_split |-> !r_sb);

endmodule

// File: tb/sim_dual_mode_shifter.sv
module sim_dual_mode_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        split = 1'b0;
  logic [2:0]  op_a = '0, op_b = '0;
  logic [5:0]  amt_a = '0;
  logic [4:0]  amt_b = '0;
  logic [63:0] din = '0;
  logic [63:0] dout;
  logic        sticky_a, sticky_b;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dual_mode_shifter u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .split(split),
    .op_a(op_a), .amt_a(amt_a), .op_b(op_b), .amt_b(amt_b),
    .din(din), .dout(dout), .sticky_a(sticky_a), .sticky_b(sticky_b)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        sp;
    logic [2:0]  oa;
    logic [5:0]  na;
    logic [2:0]  ob;
    logic [4:0]  nb;
    logic [63:0] d;
    logic [63:0] e;
    logic        es;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    // R3 and R1: lane B controls set but ignored
    '{4'd3, 1'b0, 3'd0, 6'd4,  3'd2, 5'd7, 64'h0123456789ABCDEF, 64'h00123456789ABCDE, 1'b1},
    // R4
    '{4'd4, 1'b0, 3'd1, 6'd8,  3'd0, 5'd0, 64'hF000000000000000, 64'hFFF0000000000000, 1'b0},
    // R5
    '{4'd5, 1'b0, 3'd2, 6'd60, 3'd0, 5'd0, 64'h000000000000000F, 64'hF000000000000000, 1'b0},
    // R6
    '{4'd6, 1'b0, 3'd3, 6'd32, 3'd0, 5'd0, 64'h0123456789ABCDEF, 64'h89ABCDEF01234567, 1'b0},
    // R6
    '{4'd6, 1'b0, 3'd4, 6'd4,  3'd0, 5'd0, 64'h0123456789ABCDEF, 64'h123456789ABCDEF0, 1'b0},
    // R7
    '{4'd7, 1'b0, 3'd3, 6'd0,  3'd0, 5'd0, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF, 1'b0},
    // R2: amt_a bit 5 set and ignored
    '{4'd2, 1'b1, 3'd0, 6'd36, 3'd2, 5'd8, 64'h0123456789ABCDEF, 64'h23456700089ABCDE, 1'b1},
    // R2
    '{4'd2, 1'b1, 3'd4, 6'd31, 3'd1, 5'd31, 64'h8000000000000001, 64'hFFFFFFFF80000000, 1'b0},
    // R3
    '{4'd3, 1'b0, 3'd0, 6'd63, 3'd0, 5'd0, 64'h8000000000000001, 64'h0000000000000001, 1'b1},
    // R3
    '{4'd3, 1'b0, 3'd0, 6'd1,  3'd0, 5'd0, 64'h0000000000000002, 64'h0000000000000001, 1'b0},
    // R7
    '{4'd7, 1'b0, 3'd7, 6'd5,  3'd0, 5'd0, 64'hDEADBEEFCAFEF00D, 64'hDEADBEEFCAFEF00D, 1'b0},
    // R4
    '{4'd4, 1'b0, 3'd1, 6'd63, 3'd0, 5'd0, 64'h4000000000000000, 64'h0000000000000000, 1'b0},
    // R5
    '{4'd5, 1'b0, 3'd2, 6'd1,  3'd0, 5'd0, 64'h8000000000000001, 64'h0000000000000002, 1'b0}
  };

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic void ref_lane(input logic [63:0] x, input int w, input logic [2:0] op,
                                   input int n, output logic [63:0] y, output logic s);
    y = '0;
    s = 1'b0;
    for (int i = 0; i < w; i++) begin
      case (op)
        3'd0: y[i] = (i + n < w) ? x[i+n] : 1'b0;
        3'd1: y[i] = (i + n < w) ? x[i+n] : x[w-1];
        3'd2: y[i] = (i >= n) ? x[i-n] : 1'b0;
        3'd3: y[i] = x[(i + n) % w];
        3'd4: y[i] = x[(i - n + w) % w];
        default: y[i] = x[i];
      endcase
    end
    if (op == 3'd0)
      for (int i = 0; i < n; i++) s = s | x[i];
  endfunction

  task automatic drive(input logic sp, input logic [2:0] oa, input logic [5:0] na,
                       input logic [2:0] ob, input logic [4:0] nb, input logic [63:0] d);
    split = sp; op_a = oa; amt_a = na; op_b = ob; amt_b = nb; din = d;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] ylo, yhi, yf, held;
    logic        slo, shi, sf;

    // R8 reset state
    drive(1'b0, 3'd2, 6'd3, 3'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    en = 1'b1;
    repeat (3) @(negedge clk);
    check64("R8 reset dout", dout, 64'h0);
    check1("R8 reset sticky_a", sticky_a, 1'b0);
    check1("R8 reset sticky_b", sticky_b, 1'b0);
    rst_n = 1'b1;

    // table
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v].sp, VEC[v].oa, VEC[v].na, VEC[v].ob, VEC[v].nb, VEC[v].d);
      @(negedge clk);
      @(negedge clk);
      check64($sformatf("R%0d vector %0d dout", VEC[v].tag, v), dout, VEC[v].e);
      if (VEC[v].oa == 3'd0)
        check1($sformatf("R%0d vector %0d sticky_a", VEC[v].tag, v), sticky_a, VEC[v].es);
      if (!VEC[v].sp)
        check1("R10 joined sticky_b", sticky_b, 1'b0);
    end

    // R8 latency: old value one edge after, new value two edges after
    held = dout;
    drive(1'b0, 3'd0, 6'd8, 3'd0, 5'd0, 64'hAB00_0000_0000_0000);
    @(negedge clk);
    check64("R8 one edge still old", dout, held);
    @(negedge clk);
    check64("R8 two edges new", dout, 64'h00AB_0000_0000_0000);

    // R9 hold under low enable
    held = dout;
    en = 1'b0;
    drive(1'b1, 3'd2, 6'd5, 3'd3, 5'd9, 64'h1234_5678_9ABC_DEF0);
    repeat (3) @(negedge clk);
    check64("R9 hold while en low", dout, held);
    en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ref_lane({32'h0, 32'h9ABCDEF0}, 32, 3'd2, 5, ylo, slo);
    ref_lane({32'h0, 32'h12345678}, 32, 3'd3, 9, yhi, shi);
    check64("R9 resume after en", dout, {yhi[31:0], ylo[31:0]});

    // R1 joined: lane B controls ignored
    drive(1'b0, 3'd0, 6'd40, 3'd4, 5'd31, 64'h0F0F_F0F0_1234_8001);
    @(negedge clk); @(negedge clk);
    held = dout;
    drive(1'b0, 3'd0, 6'd40, 3'd2, 5'd3, 64'h0F0F_F0F0_1234_8001);
    @(negedge clk); @(negedge clk);
    check64("R1 op_b amt_b ignored", dout, held);

    // random against reference (R1 R2 R3 R4 R5 R6 R7 R10)
    for (int t = 0; t < 400; t++) begin
      logic [63:0] d;
      logic [2:0]  oa, ob;
      logic [5:0]  na;
      logic [4:0]  nb;
      logic        sp;
      d  = {$urandom, $urandom};
      oa = 3'($urandom % 8);
      ob = 3'($urandom % 8);
      na = 6'($urandom);
      nb = 5'($urandom);
      sp = 1'($urandom);
      drive(sp, oa, na, ob, nb, d);
      @(negedge clk); @(negedge clk);
      if (sp) begin
        ref_lane({32'h0, d[31:0]}, 32, oa, int'(na[4:0]), ylo, slo);
        ref_lane({32'h0, d[63:32]}, 32, ob, int'(nb), yhi, shi);
        check64("R2 random split dout", dout, {yhi[31:0], ylo[31:0]});
        if (oa == 3'd0) check1("R3 random split sticky_a", sticky_a, slo);
        if (ob == 3'd0) check1("R3 random split sticky_b", sticky_b, shi);
      end else begin
        ref_lane(d, 64, oa, int'(na), yf, sf);
        check64("R1 random joined dout", dout, yf);
        if (oa == 3'd0) check1("R3 random joined sticky_a", sticky_a, sf);
        check1("R10 random joined sticky_b", sticky_b, 1'b0);
      end
    end

    // R8 reset clears outputs mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check64("R8 reset mid-run dout", dout, 64'h0);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule